// File: doc/BRIEF.md
# Dual-Channel Synthesizer Serial Configuration Loader

This block takes a three-wire serial stream (data, serial clock, load enable) and turns it into the static settings of a two-channel frequency synthesizer. The channels are called IF and RF. Bits enter a 23-bit shift register on each rising edge of the serial clock, most significant bit first. When load enable rises, the two lowest bits of the frame act as an address. They pick one of four holding latches: the reference word of either channel, or the program/swallow word of either channel. Only that latch takes its payload. The other three keep their contents.

All three serial inputs must already be synchronous to the block clock `clk`. The block finds their rising edges by comparing each input with its value one cycle earlier. The decoded fields come out as parallel ports. A one-cycle update strobe for each latch tells the downstream divide counters when to reload.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, every latched output and every update strobe is zero.
- R2: Each rising edge of `serClk` shifts `serData` into the frame. Bits are sent most significant first, so the last bit shifted in becomes frame bit 0.
- R3: On a rising edge of `loadEn`, the address is {frame bit 1, frame bit 0}. Code 0 writes the IF reference latch, 1 the RF reference latch, 2 the IF program latch and 3 the RF program latch. No other latch changes.
- R4: Reference frame layout: bit 2 goes to monitor select bit 0 and bit 3 to monitor select bit 1. Bits 17..4 hold the 14-bit reference ratio. Bit 18 is the high charge-pump current select. Bits 22..19 are ignored.
- R5: Program frame layout: bit 2 is the lock-output select, bit 3 the prescaler modulus select and bit 4 the phase polarity. Bits 11..5 hold the 7-bit swallow count and bits 22..12 the 11-bit program count.
- R6: Latched outputs change only on a rising edge of `loadEn`. Shifting bits, or holding `loadEn` high, leaves them unchanged.
- R7: `updStrobe[k]` is high for exactly one cycle, in the same cycle the new value of latch code k first appears at the outputs. At most one bit is high at a time.
- R8: When more than 23 bits are shifted before a load, only the last 23 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (synchronous to clk) |
| serData | input | 1 | Serial data bit |
| loadEn | input | 1 | Load enable; its rising edge writes a latch |
| ifRefRatio | output | 14 | IF reference divide ratio |
| ifCpHigh | output | 1 | IF high charge-pump current |
| ifMonSel | output | 2 | IF monitor output select |
| ifSwallow | output | 7 | IF swallow count |
| ifProg | output | 11 | IF program count |
| ifLockSel | output | 1 | IF lock-output select |
| ifPreSel | output | 1 | IF prescaler modulus select |
| ifPhasePol | output | 1 | IF phase polarity |
| rfRefRatio | output | 14 | RF reference divide ratio |
| rfCpHigh | output | 1 | RF high charge-pump current |
| rfMonSel | output | 2 | RF monitor output select |
| rfSwallow | output | 7 | RF swallow count |
| rfProg | output | 11 | RF program count |
| rfLockSel | output | 1 | RF lock-output select |
| rfPreSel | output | 1 | RF prescaler modulus select |
| rfPhasePol | output | 1 | RF phase polarity |
| updStrobe | output | 4 | One-cycle reload strobe, one bit per latch code |

## Verification
Some internal faults only show up at the next load. A shift register that is misaligned by one bit, or that shifts in the wrong direction, corrupts every field of the frame, and the bench sees this one cycle after the load edge. A wrong address decode makes a different latch's outputs change, and its strobe fires in that same cycle. An edge detector that leaks, firing on a level or while bits are shifting, makes outputs move without a load edge, or makes the strobe last longer than one cycle. Loads with extreme ratios and long frames expose field boundaries that are off by one bit.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int FRAME_W = 23;
  localparam int ADDR_W  = 2;
  localparam int REF_W   = 14;
  localparam int SWAL_W  = 7;
  localparam int PROG_W  = 11;
  localparam int N_LATCH = 1 << ADDR_W;
  localparam int SPARE_W = FRAME_W - ADDR_W - 2 - REF_W - 1;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               cpHigh;
    logic [REF_W-1:0]   ratio;
    logic [1:0]         monSel;
    logic [ADDR_W-1:0]  addr;
  } refFrame_t;

  typedef struct packed {
    logic [PROG_W-1:0] prog;
    logic [SWAL_W-1:0] swallow;
    logic              phasePol;
    logic              preSel;
    logic              lockSel;
    logic [ADDR_W-1:0] addr;
  } progFrame_t;

  typedef struct packed {
    logic               shift;
    logic [N_LATCH-1:0] wrEn;
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               loadEn,
  input  logic [ADDR_W-1:0]  addr,
  output cfgStrobe_t         strb,
  output logic [N_LATCH-1:0] updStrobe
);
  logic serClkQ, loadEnQ;
  logic loadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ   <= 1'b0;
      loadEnQ   <= 1'b0;
      updStrobe <= '0;
    end else begin
      serClkQ   <= serClk;
      loadEnQ   <= loadEn;
      updStrobe <= strb.wrEn;
    end
  end

  assign loadRise = loadEn & ~loadEnQ;

  always_comb begin
    strb.shift = serClk & ~serClkQ;
    strb.wrEn  = '0;
    if (loadRise) strb.wrEn[addr] = 1'b1;
  end
endmodule

// File: rtl/synth_cfg_data.sv
module synth_cfg_data
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  cfgStrobe_t        strb,
  output logic [ADDR_W-1:0] addr,
  output refFrame_t         refLatch  [2],
  output progFrame_t        progLatch [2]
);
  logic [FRAME_W-1:0] shiftReg;
  refFrame_t  refView;
  progFrame_t progView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], serData};
  end

  assign refView  = refFrame_t'(shiftReg);
  assign progView = progFrame_t'(shiftReg);
  assign addr     = shiftReg[ADDR_W-1:0];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refLatch[ch] <= '0;
      end else if (strb.wrEn[ch]) begin
        refLatch[ch]       <= refView;
        refLatch[ch].spare <= '0;
        refLatch[ch].addr  <= '0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        progLatch[ch] <= '0;
      end else if (strb.wrEn[ch+2]) begin
        progLatch[ch]      <= progView;
        progLatch[ch].addr <= '0;
      end
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadEn,
  output logic [REF_W-1:0]  ifRefRatio,
  output logic              ifCpHigh,
  output logic [1:0]        ifMonSel,
  output logic [SWAL_W-1:0] ifSwallow,
  output logic [PROG_W-1:0] ifProg,
  output logic              ifLockSel,
  output logic              ifPreSel,
  output logic              ifPhasePol,
  output logic [REF_W-1:0]  rfRefRatio,
  output logic              rfCpHigh,
  output logic [1:0]        rfMonSel,
  output logic [SWAL_W-1:0] rfSwallow,
  output logic [PROG_W-1:0] rfProg,
  output logic              rfLockSel,
  output logic              rfPreSel,
  output logic              rfPhasePol,
  output logic [N_LATCH-1:0] updStrobe
);
  cfgStrobe_t        strb;
  logic [ADDR_W-1:0] addr;
  refFrame_t         refLatch  [2];
  progFrame_t        progLatch [2];

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .loadEn(loadEn),
    .addr(addr), .strb(strb), .updStrobe(updStrobe)
  );

  synth_cfg_data u_data (
    .clk(clk), .rstN(rstN), .serData(serData), .strb(strb),
    .addr(addr), .refLatch(refLatch), .progLatch(progLatch)
  );

  assign ifRefRatio = refLatch[0].ratio;
  assign ifCpHigh   = refLatch[0].cpHigh;
  assign ifMonSel   = refLatch[0].monSel;
  assign rfRefRatio = refLatch[1].ratio;
  assign rfCpHigh   = refLatch[1].cpHigh;
  assign rfMonSel   = refLatch[1].monSel;
  assign ifSwallow  = progLatch[0].swallow;
  assign ifProg     = progLatch[0].prog;
  assign ifLockSel  = progLatch[0].lockSel;
  assign ifPreSel   = progLatch[0].preSel;
  assign ifPhasePol = progLatch[0].phasePol;
  assign rfSwallow  = progLatch[1].swallow;
  assign rfProg     = progLatch[1].prog;
  assign rfLockSel  = progLatch[1].lockSel;
  assign rfPreSel   = progLatch[1].preSel;
  assign rfPhasePol = progLatch[1].phasePol;
endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
  import synth_cfg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               loadEn,
  input logic [REF_W-1:0]   ifRefRatio,
  input logic [REF_W-1:0]   rfRefRatio,
  input logic [PROG_W-1:0]  ifProg,
  input logic [SWAL_W-1:0]  rfSwallow,
  input logic [N_LATCH-1:0] updStrobe
);
  // R7: never two strobes together
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updStrobe));

  // R7: strobe lasts one cycle
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|updStrobe) |=> (updStrobe == '0));

  // R3: every load edge writes exactly one latch
  p_load_writes_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadEn) |=> ($countones(updStrobe) == 1));

  // R6: no load edge, no change
  p_hold_without_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(loadEn) |=> ($stable(ifRefRatio) && $stable(rfRefRatio)
                        && $stable(ifProg) && $stable(rfSwallow)));

  // R6: no strobe means the RF reference ratio held
  p_strobe_marks_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe[1] |-> $stable(rfRefRatio));
endmodule

bind synth_cfg_loader synth_cfg_checker u_checker (
  .clk(clk), .rstN(rstN), .loadEn(loadEn),
  .ifRefRatio(ifRefRatio), .rfRefRatio(rfRefRatio),
  .ifProg(ifProg), .rfSwallow(rfSwallow), .updStrobe(updStrobe)
);

// File: tb/synth_cfg_loader_test.sv
module synth_cfg_loader_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, serClk = 0, serData = 0, loadEn = 0;
  logic [13:0] ifRefRatio, rfRefRatio;
  logic ifCpHigh, rfCpHigh, ifLockSel, rfLockSel, ifPreSel, rfPreSel;
  logic ifPhasePol, rfPhasePol;
  logic [1:0] ifMonSel, rfMonSel;
  logic [6:0] ifSwallow, rfSwallow;
  logic [10:0] ifProg, rfProg;
  logic [3:0] updStrobe;

  int nChecks = 0, nFails = 0;
  // expected model: {cs, ratio, monSel} per ref latch; {n, a, fc, sw, lds} per prog latch
  logic [16:0] expRef  [2];
  logic [20:0] expProg [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " ifRef"},  {15'd0, ifCpHigh, ifRefRatio, ifMonSel}, {15'd0, expRef[0]});
    check({tag, " rfRef"},  {15'd0, rfCpHigh, rfRefRatio, rfMonSel}, {15'd0, expRef[1]});
    check({tag, " ifProg"}, {11'd0, ifProg, ifSwallow, ifPhasePol, ifPreSel, ifLockSel},
          {11'd0, expProg[0]});
    check({tag, " rfProg"}, {11'd0, rfProg, rfSwallow, rfPhasePol, rfPreSel, rfLockSel},
          {11'd0, expProg[1]});
  endtask

  task automatic shiftBit(logic b);
    serData = b;
    @(negedge clk); serClk = 1;
    @(negedge clk); @(negedge clk); serClk = 0;
    @(negedge clk);
  endtask

  task automatic sendFrame(logic [22:0] f);
    for (int i = 22; i >= 0; i--) shiftBit(f[i]);
  endtask

  // load with loadEn held high several cycles; checks the strobe pattern (R7)
  task automatic pulseLoad(string tag, int code);
    loadEn = 1;
    @(negedge clk);
    check({tag, " R7 strobe"}, {28'd0, updStrobe}, 32'd1 << code);
    @(negedge clk);
    check({tag, " R7 strobe low"}, {28'd0, updStrobe}, 32'd0);
    @(negedge clk); @(negedge clk);
    loadEn = 0;
    @(negedge clk);
  endtask

  function automatic logic [22:0] refFrame(int code, logic [1:0] mon, logic [13:0] r, logic cs);
    return {4'b1011, cs, r, mon, code[1:0]};
  endfunction

  function automatic logic [22:0] progFrame(int code, logic [10:0] n, logic [6:0] a,
                                            logic fc, logic sw, logic lds);
    return {n, a, fc, sw, lds, code[1:0]};
  endfunction

  task automatic testReset();
    expRef = '{default: '0}; expProg = '{default: '0};
    checkAll("R1 reset");
    check("R1 strobe reset", {28'd0, updStrobe}, 0);
  endtask

  task automatic testIfRef();
    sendFrame(refFrame(0, 2'b01, 14'd16383, 1'b1));
    expRef[0] = {1'b1, 14'd16383, 2'b01};
    pulseLoad("R3 if-ref", 0);
    checkAll("R4 R3 if-ref max");
  endtask

  task automatic testRfRef();
    sendFrame(refFrame(1, 2'b10, 14'd3, 1'b0));
    expRef[1] = {1'b0, 14'd3, 2'b10};
    pulseLoad("R3 rf-ref", 1);
    checkAll("R4 R3 rf-ref min");
  endtask

  task automatic testIfProg();
    sendFrame(progFrame(2, 11'd2047, 7'd0, 1'b1, 1'b0, 1'b1));
    expProg[0] = {11'd2047, 7'd0, 1'b1, 1'b0, 1'b1};
    pulseLoad("R3 if-prog", 2);
    checkAll("R5 if-prog");
  endtask

  task automatic testRfProg();
    sendFrame(progFrame(3, 11'd3, 7'd127, 1'b0, 1'b1, 1'b0));
    expProg[1] = {11'd3, 7'd127, 1'b0, 1'b1, 1'b0};
    pulseLoad("R3 rf-prog", 3);
    checkAll("R5 rf-prog");
  endtask

  task automatic testShiftNoLoad();
    sendFrame(refFrame(0, 2'b11, 14'h2AAA, 1'b0));
    checkAll("R6 shift without load");
    check("R6 no strobe", {28'd0, updStrobe}, 0);
  endtask

  task automatic testLongFrame();
    // R2 R8: six leading junk bits, then a full frame; last 23 win
    for (int i = 0; i < 6; i++) shiftBit(i[0]);
    sendFrame(progFrame(2, 11'h555, 7'h2A, 1'b0, 1'b1, 1'b1));
    expProg[0] = {11'h555, 7'h2A, 1'b0, 1'b1, 1'b1};
    pulseLoad("R8 long", 2);
    checkAll("R8 R2 long frame");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testIfRef();
    testRfRef();
    testIfProg();
    testRfProg();
    testShiftNoLoad();
    testLongFrame();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule